// File: doc/BRIEF.md
# DRAM Bank Command Scheduler

This block sits between a requester and a multi-bank DRAM. It keeps up to eight pending read and write references. For each one it issues the precharge, row-activate and column commands that the reference needs, over one multiplexed address bus. The row address goes out with the activate and the column address goes out with the later column command. The block keeps an open-row record for each bank and uses it to decide whether a reference is a row hit, a row conflict or a closed-bank access.

A two-bit configuration input selects the policy that picks, each cycle, the one reference whose next command issues:
- **In-order** serves only the oldest reference.
- **Column-first** serves row hits before anything else.
- **First-ready** lets any reference with a legal command go, so work on one bank overlaps the waiting time of another.

In every policy, ties go to the oldest reference. A reference retires when its column command issues, and the block reports its tag in that same cycle. Simple per-bank down-counters stand in for the device timing.

Top module: `dram_cmd_sched`

## Requirements
- R1: After reset no command or completion is driven, `req_ready` is high and every bank is treated as closed.
- R2: Command codes are 0 none, 1 precharge, 2 activate, 3 read, 4 write. A reference to a closed bank first gets an activate that carries its row on `cmd_addr`, and later gets a read or write that carries its column on `cmd_addr`. A precharge drives `cmd_addr` to 0.
- R3: A reference whose bank has a different row open gets a precharge, then an activate, then its column command, in that order.
- R4: A reference whose row is already open in its bank gets only its column command, with no precharge or activate.
- R5: On any one bank, at least 2 cycles separate a precharge from the next activate, and at least 2 cycles separate an activate from the next command to that bank.
- R6: With `policy` = 0 (in-order), only the oldest pending reference may issue a command.
- R7: With `policy` = 1 (column-first), the oldest row-hit reference whose bank is ready is served before any reference that needs a precharge or activate.
- R8: With `policy` = 2 or 3 (first-ready), the oldest reference whose next command is legal in that cycle issues, even when older references are waiting on a busy bank.
- R9: At most one command issues per cycle. `done_valid` pulses with the reference's tag in exactly the cycle its read or write issues, and the reference then leaves the queue.
- R10: The queue holds 8 references. `req_ready` is low exactly when 8 are pending, and a request is accepted only when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 0 in-order, 1 column-first, 2/3 first-ready |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has space |
| req_bank | input | 2 | Target bank |
| req_row | input | 8 | Row address |
| req_col | input | 6 | Column address |
| req_write | input | 1 | 1 write, 0 read |
| req_tag | input | 4 | Tag returned on completion |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_code | output | 3 | Command code (see R2) |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | 8 | Row or column on the shared address bus |
| done_valid | output | 1 | Completion strobe |
| done_tag | output | 4 | Tag of the completed reference |

## Verification
The command and completion outputs are combinational from the queue, the bank records and the timers. A wrong open-row record or timer therefore shows up in the first cycle in which a reference to that bank is eligible: a precharge appears where a column command was due, or the reverse, or a command shows up early or late by a cycle. A wrong queue order shows up as a different tag order on `done_valid`, and the three policy scenarios are laid out so that each policy produces its own tag order. The bench runs a behavioural model alongside the design and compares every output in every cycle, so a discrepancy is reported in the cycle it first appears.

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched #(
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int TAG_W = 4,
  parameter int DEPTH = 8,
  parameter int T_RP  = 2,
  parameter int T_RCD = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             policy,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [$clog2(NBANK)-1:0]               req_bank,
  input  logic [ROW_W-1:0]                       req_row,
  input  logic [COL_W-1:0]                       req_col,
  input  logic                                   req_write,
  input  logic [TAG_W-1:0]                       req_tag,
  output logic                                   cmd_valid,
  output logic [2:0]                             cmd_code,
  output logic [$clog2(NBANK)-1:0]               cmd_bank,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]   cmd_addr,
  output logic                                   done_valid,
  output logic [TAG_W-1:0]                       done_tag
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int TMR_W  = $clog2(((T_RP > T_RCD) ? T_RP : T_RCD) + 1);
  localparam logic [2:0] C_PRE = 3'd1, C_ACT = 3'd2, C_RD = 3'd3, C_WR = 3'd4;
  localparam logic [1:0] K_COL = 2'd0, K_PRE = 2'd1, K_ACT = 2'd2;

  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  logic [COL_W-1:0]  q_col  [DEPTH];
  logic              q_wr   [DEPTH];
  logic [TAG_W-1:0]  q_tag  [DEPTH];
  logic [CNT_W-1:0]  count;

  logic              bank_open [NBANK];
  logic [ROW_W-1:0]  open_row  [NBANK];
  logic [TMR_W-1:0]  tmr       [NBANK];

  logic [1:0]        kind [DEPTH];
  logic [DEPTH-1:0]  elig, hit, mask;
  logic [IDX_W-1:0]  sel;
  logic [1:0]        sel_kind;
  logic              accept, deq;
  logic [CNT_W-1:0]  wr_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!bank_open[q_bank[i]])                 kind[i] = K_ACT;
      else if (open_row[q_bank[i]] == q_row[i])  kind[i] = K_COL;
      else                                       kind[i] = K_PRE;
      elig[i] = (CNT_W'(i) < count) && (tmr[q_bank[i]] == '0);
      hit[i]  = elig[i] && (kind[i] == K_COL);
    end
    if (policy == 2'd0)              mask = elig & DEPTH'(1);
    else if (policy == 2'd1 && |hit) mask = hit;
    else                             mask = elig;
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (mask[i]) sel = IDX_W'(i);
  end

  assign sel_kind   = kind[sel];
  assign cmd_valid  = |mask;
  assign cmd_bank   = q_bank[sel];
  assign cmd_code   = !cmd_valid ? 3'd0 : sel_kind == K_PRE ? C_PRE :
                      sel_kind == K_ACT ? C_ACT : (q_wr[sel] ? C_WR : C_RD);
  assign cmd_addr   = !cmd_valid ? '0 : sel_kind == K_ACT ? ADDR_W'(q_row[sel]) :
                      sel_kind == K_COL ? ADDR_W'(q_col[sel]) : '0;
  assign deq        = cmd_valid && sel_kind == K_COL;
  assign done_valid = deq;
  assign done_tag   = q_tag[sel];
  assign req_ready  = count < CNT_W'(DEPTH);
  assign accept     = req_valid && req_ready;
  assign wr_idx     = count - CNT_W'(deq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int b = 0; b < NBANK; b++) begin
        bank_open[b] <= 1'b0;
        open_row[b]  <= '0;
        tmr[b]       <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (tmr[b] != '0) tmr[b] <= tmr[b] - 1'b1;
        if (cmd_valid && cmd_bank == BANK_W'(b)) begin
          if (sel_kind == K_PRE) begin
            bank_open[b] <= 1'b0;
            tmr[b]       <= TMR_W'(T_RP - 1);
          end else if (sel_kind == K_ACT) begin
            bank_open[b] <= 1'b1;
            open_row[b]  <= q_row[sel];
            tmr[b]       <= TMR_W'(T_RCD - 1);
          end
        end
      end
      for (int i = 0; i < DEPTH - 1; i++)
        if (deq && IDX_W'(i) >= sel) begin
          q_bank[i] <= q_bank[i+1];
          q_row[i]  <= q_row[i+1];
          q_col[i]  <= q_col[i+1];
          q_wr[i]   <= q_wr[i+1];
          q_tag[i]  <= q_tag[i+1];
        end
      if (accept) begin
        q_bank[wr_idx[IDX_W-1:0]] <= req_bank;
        q_row[wr_idx[IDX_W-1:0]]  <= req_row;
        q_col[wr_idx[IDX_W-1:0]]  <= req_col;
        q_wr[wr_idx[IDX_W-1:0]]   <= req_write;
        q_tag[wr_idx[IDX_W-1:0]]  <= req_tag;
      end
      count <= count + CNT_W'(accept) - CNT_W'(deq);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R10
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !deq) |=> (count == CNT_W'(DEPTH))); // R10
  AST_DONE_IS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (cmd_code == C_RD || cmd_code == C_WR)); // R9
  AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_RD || cmd_code == C_WR) |-> bank_open[cmd_bank]); // R4
  AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_PRE) |-> bank_open[cmd_bank]); // R3
  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_PRE) |=> !(cmd_code == C_ACT && cmd_bank == $past(cmd_bank))); // R5
  AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_ACT) |=> !(cmd_valid && cmd_bank == $past(cmd_bank))); // R5
  AST_INORDER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd0 && done_valid) |-> (done_tag == q_tag[0])); // R6
endmodule

// File: tb/dram_cmd_sched_tb.sv
module dram_cmd_sched_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic [3:0] req_tag = '0;
  logic       req_ready, cmd_valid, done_valid;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_addr;
  logic [3:0] done_tag;

  always #10 clk = ~clk;

  dram_cmd_sched u_dut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_tag(req_tag), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .done_valid(done_valid), .done_tag(done_tag));

  typedef struct {int bank; int row; int col; int wr; int tag;} ref_t;
  ref_t mq[$];
  int bo[4], br[4], bt[4];
  int checks = 0, errors = 0;
  int lcode[$], laddr[$], lbank[$], dq[$];
  int full_seen;

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic string pol_req();
    return policy == 2'd0 ? "R6" : policy == 2'd1 ? "R7" : "R8";
  endfunction

  task automatic model_reset();
    mq.delete();
    for (int b = 0; b < 4; b++) begin bo[b] = 0; br[b] = 0; bt[b] = 0; end
  endtask

  task automatic cyc(input int v, input int b, input int r, input int c, input int w, input int t);
    int s, k, sz, ecode;
    req_valid = v[0]; req_bank = b[1:0]; req_row = r[7:0]; req_col = c[5:0];
    req_write = w[0]; req_tag = t[3:0];
    #2;
    s = -1; k = 0; sz = mq.size();
    for (int i = 0; i < sz; i++) begin
      int ki;
      bit el;
      if (policy == 2'd0 && i > 0) break;
      ki = !bo[mq[i].bank] ? 2 : (br[mq[i].bank] == mq[i].row ? 0 : 1);
      el = bt[mq[i].bank] == 0;
      if (el && policy == 2'd1 && ki == 0) begin s = i; k = 0; break; end
      if (el && s < 0) begin
        s = i; k = ki;
        if (policy != 2'd1) break;
      end
    end
    chk("R10", "req_ready", req_ready, sz < 8);
    chk(pol_req(), "cmd_valid", cmd_valid, s >= 0);
    chk("R9", "done_valid", done_valid, s >= 0 && k == 0);
    if (s >= 0) begin
      ecode = k == 1 ? 1 : k == 2 ? 2 : (mq[s].wr ? 4 : 3);
      chk(pol_req(), "cmd_code", cmd_code, ecode);
      chk(pol_req(), "cmd_bank", cmd_bank, mq[s].bank);
      chk("R2", "cmd_addr", cmd_addr, k == 2 ? mq[s].row : k == 0 ? mq[s].col : 0);
      if (k == 0) chk("R9", "done_tag", done_tag, mq[s].tag);
    end
    lcode.push_back(cmd_valid ? int'(cmd_code) : 0);
    laddr.push_back(int'(cmd_addr));
    lbank.push_back(int'(cmd_bank));
    if (done_valid) dq.push_back(int'(done_tag));
    if (!req_ready) full_seen++;
    for (int bb = 0; bb < 4; bb++) if (bt[bb] > 0) bt[bb]--;
    if (s >= 0) begin
      if (k == 1) begin bo[mq[s].bank] = 0; bt[mq[s].bank] = 1; end
      else if (k == 2) begin bo[mq[s].bank] = 1; br[mq[s].bank] = mq[s].row; bt[mq[s].bank] = 1; end
      else mq.delete(s);
    end
    if (v != 0 && sz < 8) mq.push_back('{b, r, c, w, t});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic clear_logs();
    lcode.delete(); laddr.delete(); lbank.delete(); dq.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic policy_case(input int p, input int e0, input int e1, input int e2, input int e3, input string r);
    do_reset();
    policy = p[1:0];
    clear_logs();
    cyc(1, 0, 1, 10, 0, 1);
    cyc(1, 0, 2, 11, 0, 2);
    cyc(1, 0, 1, 12, 1, 3);
    cyc(1, 1, 3, 13, 0, 4);
    idle(25);
    chk(r, "done count", dq.size(), 4);
    if (dq.size() == 4) begin
      chk(r, "done order 0", dq[0], e0);
      chk(r, "done order 1", dq[1], e1);
      chk(r, "done order 2", dq[2], e2);
      chk(r, "done order 3", dq[3], e3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 100000 expected fewer cycles");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    #2;
    chk("R1", "cmd_valid after reset", cmd_valid, 0);
    chk("R1", "done_valid after reset", done_valid, 0);
    chk("R1", "req_ready after reset", req_ready, 1);
    @(negedge clk);

    // R2 closed bank: ACT row, then column one gap later
    policy = 2'd0;
    clear_logs();
    cyc(1, 1, 5, 3, 0, 1);
    idle(4);
    chk("R1", "no cmd in accept cycle", lcode[0], 0);
    chk("R2", "activate first", lcode[1], 2);
    chk("R2", "activate carries row", laddr[1], 5);
    chk("R5", "gap after activate", lcode[2], 0);
    chk("R2", "read after activate", lcode[3], 3);
    chk("R2", "read carries column", laddr[3], 3);

    // R4 hit: only the column command
    clear_logs();
    cyc(1, 1, 5, 7, 1, 2);
    idle(3);
    chk("R4", "hit issues write at once", lcode[1], 4);
    chk("R4", "hit write column", laddr[1], 7);
    chk("R4", "no further command", lcode[2] + lcode[3], 0);

    // R3 conflict: PRE, ACT, column
    clear_logs();
    cyc(1, 1, 9, 1, 0, 3);
    idle(6);
    chk("R3", "precharge first", lcode[1], 1);
    chk("R2", "precharge address zero", laddr[1], 0);
    chk("R5", "gap after precharge", lcode[2], 0);
    chk("R3", "activate second", lcode[3], 2);
    chk("R3", "activate row", laddr[3], 9);
    chk("R5", "gap after activate", lcode[4], 0);
    chk("R3", "read third", lcode[5], 3);

    // R10 fill the queue with alternating-row misses on one bank
    full_seen = 0;
    for (int i = 0; i < 14; i++) cyc(1, 2, i % 2 + 20, i, 0, i);
    idle(80);
    chk("R10", "queue reached full", full_seen > 0, 1);
    chk("R10", "queue drained", req_ready, 1);

    // R6 R7 R8 distinct completion orders
    policy_case(0, 1, 2, 3, 4, "R6");
    policy_case(1, 1, 3, 4, 2, "R7");
    policy_case(2, 1, 4, 2, 3, "R8");
    policy_case(3, 1, 4, 2, 3, "R8");

    // mixed traffic under every policy, compared each cycle
    for (int p = 0; p < 4; p++) begin
      do_reset();
      policy = p[1:0];
      for (int i = 0; i < 400; i++)
        cyc(($urandom % 2), ($urandom % 4), ($urandom % 3), ($urandom % 64), ($urandom % 2), i % 16);
      idle(80);
      chk("R9", "all retired", req_ready, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule